// File: doc/BRIEF.md
# Command and Interrupt Register Block

This block is the host-visible register file of an Ethernet controller: sixty-four 16-bit words behind one write port and one read port. Each write is filtered by a rule that belongs to the register it addresses. The rules are:

- masking off read-only bits;
- forcing an address to word alignment;
- storing the one's complement of the data;
- refusing the write outside reset mode;
- clearing status bits that are written as one.

Word 0 is the command register. A write to it is turned into one-clock action pulses for the engines around the block. Those engines cover transmit, halt, receiver on/off, timer start/stop, software reset, receive-resource fetch and address-table load.

The transmit, resource-fetch and table-load engines report completion through a three-bit done input. That input retires their command bits. Any engine may raise status bits through a set vector. A single interrupt line is high while any enabled status bit is pending.

The word map is as follows:

| Address | Register |
|---|---|
| 0 | command |
| 1 | interrupt enable |
| 2 | status |
| 3 | configuration |
| 4 | secondary configuration |
| 5 | transmit control |
| 6 | receive control |
| 7 | end-of-buffer count |
| 8 to 11 | receive ring pointers |
| 12 to 14 | error tallies |
| 15 and up | plain storage |

Command bit positions:

| Bit | Action |
|---|---|
| 0 | halt |
| 1 | transmit |
| 2 | receiver off |
| 3 | receiver on |
| 4 | timer stop |
| 5 | timer start |
| 7 | software reset (reset mode) |
| 8 | resource fetch |
| 9 | table load |

Top module: `nic_ctrl_regfile`

## Requirements
- R1: After hardware reset the command word reads 0x0094 (reset mode, timer stop, receiver off), the end-of-buffer count reads 0x02F8, the enable and status words read 0, cmdPulse is 0 and irqOut is low.
- R2: irqOut is high exactly when the bitwise AND of the enable word (address 1) and the status word (address 2) is non-zero.
- R3: A write to the status word clears those written-one bits that are set, and leaves bits written as zero untouched. A bit raised on statusSet in the same cycle stays set.
- R4: In reset mode (command bit 7 set), a command write with bit 7 clear only clears bit 7. No other command bit changes and no pulse fires.
- R5: Any other command write ORs data & 0x03BF into the command word. The same bits appear on cmdPulse, at the same bit positions and all together, for exactly the one cycle after the write. Bits 6 and 15:10 never pulse.
- R6: The configuration word (address 3, keeps mask 0xBFFF) and the secondary configuration word (address 4, keeps mask 0xF017) accept writes only in reset mode. Writes at other times leave them unchanged.
- R7: The three error tallies (addresses 12 to 14) store the bitwise inverse of the written data.
- R8: Transmit control (address 5) keeps only bits 15:12, receive control (address 6) keeps only bits 15:5, and the enable word ignores bit 15.
- R9: The four receive ring pointers (addresses 8 to 11) store the written data with bit 0 forced to 0.
- R10: engineDone bit 0, 1 and 2 clear command bit 1, 8 and 9 respectively. A host command write that sets the same bit in the same cycle wins.
- R11: Address 7 and addresses 15 and up store data as written. rdData shows the word at rdAddr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low hardware reset |
| wrEn | input | 1 | write strobe |
| wrAddr | input | ADDR_W | word address of the write |
| wrData | input | 16 | write data |
| rdAddr | input | ADDR_W | word address to read |
| rdData | output | 16 | registered read data |
| engineDone | input | 3 | done strobes: transmit, resource fetch, table load |
| statusSet | input | 16 | status bits to raise this cycle |
| cmdPulse | output | 16 | one-cycle action pulses, positioned as the command bits |
| irqOut | output | 1 | interrupt request |

## Verification
The bench sweeps every command bit on its own and all bits together. A design that pulsed a dead bit, or kept a pulse for two cycles, shows it on cmdPulse. Release from reset mode is exercised with a command that carries other bits; a design that acted on them would pulse or set command bits. The bench drives a done strobe and a host command in the same cycle, and a status set and a status clear in the same cycle, to show which side wins; a wrong priority loses a pending request or an event. Configuration writes are tried both inside and outside reset mode. The bench also walks one enable bit over all sixteen positions, including the ignored bit 15, so a stored bit 15 would raise a false interrupt.

// File: rtl/nic_ctrl_pkg.sv
package nic_ctrl_pkg;

  localparam int DATA_W = 16;

  // word map
  localparam int A_CMD    = 0;
  localparam int A_IMASK  = 1;
  localparam int A_ISTAT  = 2;
  localparam int A_CFG    = 3;
  localparam int A_CFG2   = 4;
  localparam int A_TXC    = 5;
  localparam int A_RXC    = 6;
  localparam int A_EOB    = 7;
  localparam int A_RING0  = 8;
  localparam int A_TALLY0 = 12;
  localparam int RING_N   = 4;
  localparam int TALLY_N  = 3;

  // command bit positions that neighbours decode
  localparam int CB_TX  = 1;
  localparam int CB_RST = 7;
  localparam int CB_RRA = 8;
  localparam int CB_CAM = 9;

  localparam logic [DATA_W-1:0] CMD_LIVE      = 16'h03BF;
  localparam logic [DATA_W-1:0] CMD_RESET_VAL = 16'h0094;
  localparam logic [DATA_W-1:0] EOB_RESET_VAL = 16'h02F8;

  typedef enum logic [3:0] {
    K_PLAIN, K_CMD, K_STAT, K_MASK, K_CFG, K_CFG2, K_TXC, K_RXC, K_RING, K_TALLY
  } regKind_e;

  typedef struct packed {
    logic relReset;  // leave reset mode, nothing else
    logic cmdOr;     // merge command bits and fire pulses
    logic regWr;     // allowed write to a non-command word
  } wrStrobe_t;

  function automatic regKind_e addrKind(int a);
    if (a == A_CMD)                                   return K_CMD;
    if (a == A_ISTAT)                                 return K_STAT;
    if (a == A_IMASK)                                 return K_MASK;
    if (a == A_CFG)                                   return K_CFG;
    if (a == A_CFG2)                                  return K_CFG2;
    if (a == A_TXC)                                   return K_TXC;
    if (a == A_RXC)                                   return K_RXC;
    if (a >= A_RING0 && a < A_RING0 + RING_N)         return K_RING;
    if (a >= A_TALLY0 && a < A_TALLY0 + TALLY_N)      return K_TALLY;
    return K_PLAIN;
  endfunction

  function automatic logic [DATA_W-1:0] keepMask(regKind_e k);
    case (k)
      K_MASK:  return 16'h7FFF;
      K_CFG:   return 16'hBFFF;
      K_CFG2:  return 16'hF017;
      K_TXC:   return 16'hF000;
      K_RXC:   return 16'hFFE0;
      K_RING:  return 16'hFFFE;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] storeRule(regKind_e k, logic [DATA_W-1:0] d);
    if (k == K_TALLY) return ~d;
    return d & keepMask(k);
  endfunction

  function automatic logic [DATA_W-1:0] resetValue(int a);
    if (a == A_CMD) return CMD_RESET_VAL;
    if (a == A_EOB) return EOB_RESET_VAL;
    return '0;
  endfunction

endpackage

// File: rtl/nic_ctrl_cmd.sv
module nic_ctrl_cmd
  import nic_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              resetMode,
  output wrStrobe_t         st,
  output logic [DATA_W-1:0] pulse
);

  logic isCmd;
  logic cfgHit;

  assign isCmd  = wrEn && (wrAddr == ADDR_W'(A_CMD));
  assign cfgHit = (wrAddr == ADDR_W'(A_CFG)) || (wrAddr == ADDR_W'(A_CFG2));

  always_comb begin
    st.relReset = isCmd && resetMode && !wrData[CB_RST];
    st.cmdOr    = isCmd && !(resetMode && !wrData[CB_RST]);
    st.regWr    = wrEn && !isCmd && !(cfgHit && !resetMode);
  end

  // one flop per live command bit, dead bits tied low
  for (genvar b = 0; b < DATA_W; b++) begin : g_pulse
    if (CMD_LIVE[b]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= st.cmdOr & wrData[b];
      end
      assign pulse[b] = q;
    end else begin : g_dead
      assign pulse[b] = 1'b0;
    end
  end

  // R4
  rel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.relReset |=> (pulse == '0));

endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         st,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [2:0]        engineDone,
  input  logic [DATA_W-1:0] statusSet,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cmdQ,
  output logic              irq
);

  localparam int NUM_REGS = 1 << ADDR_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] regFlat;
  logic [DATA_W-1:0]               doneMask;

  always_comb begin
    doneMask         = '0;
    doneMask[CB_TX]  = engineDone[0];
    doneMask[CB_RRA] = engineDone[1];
    doneMask[CB_CAM] = engineDone[2];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    localparam regKind_e K = addrKind(g);
    logic [DATA_W-1:0] q;

    if (K == K_CMD) begin : g_cmd
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            q <= resetValue(g);
        else if (st.relReset) q <= q & ~doneMask & ~(DATA_W'(1) << CB_RST);
        else if (st.cmdOr)    q <= (q & ~doneMask) | (wrData & CMD_LIVE);
        else                  q <= q & ~doneMask;
      end
    end else if (K == K_STAT) begin : g_stat
      logic hit;
      assign hit = st.regWr && (wrAddr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= resetValue(g);
        else       q <= (hit ? (q & ~wrData) : q) | statusSet;
      end
    end else begin : g_rule
      logic hit;
      assign hit = st.regWr && (wrAddr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   q <= resetValue(g);
        else if (hit) q <= storeRule(K, wrData);
      end
    end

    assign regFlat[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= regFlat[rdAddr];
  end

  assign cmdQ = regFlat[A_CMD];
  assign irq  = |(regFlat[A_IMASK] & regFlat[A_ISTAT]);

  // R3
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(st.regWr && wrAddr == ADDR_W'(A_ISTAT)) && statusSet == '0)
      |=> $stable(regFlat[A_ISTAT]));

  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdQ[CB_RST] |=> ($stable(regFlat[A_CFG]) && $stable(regFlat[A_CFG2])));

  // R7
  tally_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.regWr && wrAddr == ADDR_W'(A_TALLY0)) |=> (regFlat[A_TALLY0] == ~$past(wrData)));

  // R10
  done_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engineDone[0] && !(st.cmdOr && wrData[CB_TX])) |=> !cmdQ[CB_TX]);

endmodule

// File: rtl/nic_ctrl_regfile.sv
module nic_ctrl_regfile
  import nic_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [2:0]        engineDone,
  input  logic [DATA_W-1:0] statusSet,
  output logic [DATA_W-1:0] cmdPulse,
  output logic              irqOut
);

  wrStrobe_t         strobes;
  logic [DATA_W-1:0] cmdQ;

  nic_ctrl_cmd #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .resetMode (cmdQ[CB_RST]),
    .st        (strobes),
    .pulse     (cmdPulse)
  );

  nic_ctrl_regs #(.ADDR_W(ADDR_W)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .engineDone (engineDone),
    .statusSet  (statusSet),
    .rdData     (rdData),
    .cmdQ       (cmdQ),
    .irq        (irqOut)
  );

  // R5
  pulse_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse != '0) |-> ((cmdQ & cmdPulse) == cmdPulse));

endmodule

// File: tb/nic_ctrl_regfile_tb_top.sv
module nic_ctrl_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [2:0]  engineDone = '0;
  logic [15:0] statusSet = '0;
  logic [15:0] cmdPulse;
  logic        irqOut;

  int          errs = 0;
  int          checks = 0;
  bit          finished = 0;
  logic [15:0] expCmd;

  always #5 clk = ~clk;

  nic_ctrl_regfile #(.ADDR_W(6)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .engineDone(engineDone),
    .statusSet(statusSet), .cmdPulse(cmdPulse), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    d = rdData;
  endtask

  task automatic setStat(input logic [15:0] v);
    @(negedge clk);
    statusSet = v;
    @(negedge clk);
    statusSet = '0;
  endtask

  task automatic fireDone(input int idx);
    @(negedge clk);
    engineDone = 3'(1 << idx);
    @(negedge clk);
    engineDone = '0;
  endtask

  task automatic cmdWrite(input logic [15:0] v);
    logic [15:0] expPulse;
    logic [15:0] got;
    string       tag;
    if (expCmd[7] && !v[7]) begin
      expPulse = '0; expCmd[7] = 1'b0; tag = "R4";
    end else begin
      expPulse = v & 16'h03BF; expCmd = expCmd | expPulse; tag = "R5";
    end
    wr(6'd0, v);
    chk({tag, " pulse"}, cmdPulse, expPulse);
    @(negedge clk);
    chk({tag, " pulse one cycle"}, cmdPulse, 16'h0000);
    rd(6'd0, got);
    chk({tag, " command word"}, got, expCmd);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expCmd = 16'h0094;

    // R1 reset state
    chk("R1 pulse", cmdPulse, 16'h0000);
    chk("R1 irq", {15'd0, irqOut}, 16'h0000);
    rd(6'd0, got);  chk("R1 command", got, 16'h0094);
    rd(6'd7, got);  chk("R1 eob count", got, 16'h02F8);
    rd(6'd1, got);  chk("R1 enable", got, 16'h0000);
    rd(6'd2, got);  chk("R1 status", got, 16'h0000);
    rd(6'd32, got); chk("R1 plain", got, 16'h0000);

    // R6 writes accepted in reset mode
    wr(6'd3, 16'hFFFF); rd(6'd3, got); chk("R6 cfg in reset", got, 16'hBFFF);
    wr(6'd4, 16'hFFFF); rd(6'd4, got); chk("R6 cfg2 in reset", got, 16'hF017);

    // R4 release ignores the transmit bit
    cmdWrite(16'h0002);

    // R6 writes refused outside reset mode
    wr(6'd3, 16'h0000); rd(6'd3, got); chk("R6 cfg locked", got, 16'hBFFF);
    wr(6'd4, 16'h0000); rd(6'd4, got); chk("R6 cfg2 locked", got, 16'hF017);

    // R5 one bit at a time
    for (int b = 0; b < 16; b++) begin
      cmdWrite(16'(1 << b));
      if (b == 7) cmdWrite(16'h0000);
    end
    // R5 all bits together, then R4 release
    cmdWrite(16'hFFFF);
    cmdWrite(16'h0000);

    // R10 done strobes retire their bits
    fireDone(0); expCmd[1] = 1'b0; rd(6'd0, got); chk("R10 tx done", got, expCmd);
    fireDone(1); expCmd[8] = 1'b0; rd(6'd0, got); chk("R10 fetch done", got, expCmd);
    fireDone(2); expCmd[9] = 1'b0; rd(6'd0, got); chk("R10 load done", got, expCmd);
    // R10 host write wins over a same-cycle done
    @(negedge clk);
    engineDone = 3'b001; wrEn = 1'b1; wrAddr = 6'd0; wrData = 16'h0002;
    @(negedge clk);
    engineDone = '0; wrEn = 1'b0;
    chk("R10 conflict pulse", cmdPulse, 16'h0002);
    expCmd[1] = 1'b1;
    rd(6'd0, got); chk("R10 conflict command", got, expCmd);

    // R2 walking enable bit, R8 bit 15 ignored
    for (int i = 0; i < 16; i++) begin
      wr(6'd1, 16'(1 << i));
      setStat(16'(1 << i));
      chk("R2 irq matching bit", {15'd0, irqOut}, (i != 15) ? 16'h0001 : 16'h0000);
      wr(6'd2, 16'hFFFF);
      rd(6'd2, got); chk("R3 clear all", got, 16'h0000);
      chk("R2 irq after clear", {15'd0, irqOut}, 16'h0000);
      setStat(~16'(1 << i));
      chk("R2 irq other bits", {15'd0, irqOut}, 16'h0000);
      wr(6'd2, 16'hFFFF);
    end
    wr(6'd1, 16'hFFFF); rd(6'd1, got); chk("R8 enable mask", got, 16'h7FFF);

    // R3 partial clear and set-wins
    setStat(16'h00F3);
    wr(6'd2, 16'h0F11); rd(6'd2, got); chk("R3 partial clear", got, 16'h00E2);
    @(negedge clk);
    statusSet = 16'h0002; wrEn = 1'b1; wrAddr = 6'd2; wrData = 16'h0002;
    @(negedge clk);
    statusSet = '0; wrEn = 1'b0;
    rd(6'd2, got); chk("R3 set wins", got, 16'h00E2);
    chk("R2 irq pending", {15'd0, irqOut}, 16'h0001);
    wr(6'd2, 16'hFFFF);

    // R7 tallies
    for (int a = 12; a < 15; a++) begin
      wr(6'(a), 16'h0000); rd(6'(a), got); chk("R7 tally zero", got, 16'hFFFF);
      wr(6'(a), 16'hA5C3); rd(6'(a), got); chk("R7 tally pattern", got, 16'h5A3C);
      wr(6'(a), 16'hFFFF); rd(6'(a), got); chk("R7 tally ones", got, 16'h0000);
    end

    // R8 control words
    wr(6'd5, 16'hFFFF); rd(6'd5, got); chk("R8 tx ctl", got, 16'hF000);
    wr(6'd5, 16'h1ABC); rd(6'd5, got); chk("R8 tx ctl pattern", got, 16'h1000);
    wr(6'd6, 16'hFFFF); rd(6'd6, got); chk("R8 rx ctl", got, 16'hFFE0);
    wr(6'd6, 16'h001F); rd(6'd6, got); chk("R8 rx ctl low", got, 16'h0000);

    // R9 ring pointers
    for (int a = 8; a < 12; a++) begin
      wr(6'(a), 16'h1235 + 16'(a)); rd(6'(a), got);
      chk("R9 ring align", got, (16'h1235 + 16'(a)) & 16'hFFFE);
    end

    // R11 plain words
    wr(6'd7, 16'h0BEE);
    for (int a = 15; a < 64; a++) wr(6'(a), (16'(a) * 16'h0101) ^ 16'h5A3C);
    rd(6'd7, got); chk("R11 eob plain", got, 16'h0BEE);
    for (int a = 15; a < 64; a++) begin
      rd(6'(a), got);
      chk("R11 plain", got, (16'(a) * 16'h0101) ^ 16'h5A3C);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule